// File: doc/BRIEF.md
# Four-Line Exact Recency Tracker

This block keeps the exact least-recently-used order of four lines, which may be the four ways of one cache set or the entries of a small fully associative buffer. One instance serves one set. Each cycle it may receive one reference, given as a strobe and a 2-bit line index. The referenced line becomes the most recent. The lines that were more recent than it each move down one place, and the lines that were older keep their order. The output is the index of the line at the old end of the ordering, which the surrounding cache uses as its replacement victim.

The ordering is held as four 2-bit slots, from most recent to least recent, so every legal state is one of the 24 permutations of the four lines. A single-bit two-line tracker runs alongside it and sees the same references. A mode input chooses which of the two trackers drives the victim output. The two-line view is meant for comparison and testing against the four-line one.

Top module: `lru4_tracker`

## Requirements
- R1: After reset, the victim is line 3 in four-line mode (order 0,1,2,3 from most to least recent) and line 1 in two-line mode.
- R2: A valid reference to line x in four-line state puts x in the most-recent slot. Lines that were more recent than x shift one slot toward the old end, and older lines keep their slots, so the slots always hold a permutation of 0..3.
- R3: In four-line mode the victim is the line in the least-recent slot, so it is never the line referenced in the previous valid cycle.
- R4: When acc_valid is low, both trackers hold their state and the victim does not change.
- R5: A reference to the line that is already most recent leaves the four-line state unchanged.
- R6: In the two-line tracker, a reference to line 0 makes line 1 the victim, and a reference to line 1 makes line 0 the victim.
- R7: References to lines 2 and 3 leave the two-line tracker unchanged.
- R8: Both trackers update on every valid reference whatever the mode. pair_mode (1 = two-line, 0 = four-line) only selects which tracker drives victim, and the selection takes effect combinationally in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| pair_mode | input | 1 | 1 selects the two-line victim, 0 selects the four-line victim |
| acc_valid | input | 1 | A reference is present this cycle |
| acc_line | input | 2 | Index of the referenced line |
| victim | output | 2 | Index of the current least-recently-used line |

## Verification
The bench goes after references to the line that is already most recent. A design that reordered on every hit would move lines there when it should hold. It also references the least-recent line, where a shift that is off by one slot would drop or duplicate an index, and it issues idle cycles, where a design that updated without the strobe would drift. Two-line checks use lines 2 and 3 to catch a tracker that decoded only the low index bit. They also switch the mode after a stretch of history, to catch a design that froze one tracker while the other was selected.

// File: rtl/lru4_tracker.sv
module lru4_tracker #(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pair_mode,
  input  logic             acc_valid,
  input  logic [IDX_W-1:0] acc_line,
  output logic [IDX_W-1:0] victim
);
  localparam int SLOTS = 1 << IDX_W;
  localparam int ORD_W = SLOTS * IDX_W;

  logic [ORD_W-1:0] order_q, order_d, order_init;
  logic [IDX_W-1:0] hit_pos;
  logic             pair_q;

  always_comb begin
    for (int i = 0; i < SLOTS; i++)
      order_init[i*IDX_W +: IDX_W] = IDX_W'(i);
  end

  always_comb begin
    hit_pos = '0;
    for (int i = 0; i < SLOTS; i++)
      if (order_q[i*IDX_W +: IDX_W] == acc_line) hit_pos = IDX_W'(i);
  end

  always_comb begin
    order_d = order_q;
    if (acc_valid) begin
      order_d[IDX_W-1:0] = acc_line;
      for (int i = 1; i < SLOTS; i++)
        if (IDX_W'(i) <= hit_pos)
          order_d[i*IDX_W +: IDX_W] = order_q[(i-1)*IDX_W +: IDX_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      order_q <= order_init;
      pair_q  <= 1'b1;
    end else begin
      order_q <= order_d;
      if (acc_valid && acc_line[IDX_W-1:1] == '0)
        pair_q <= ~acc_line[0];
    end
  end

  assign victim = pair_mode ? IDX_W'(pair_q) : order_q[ORD_W-1 -: IDX_W];
endmodule

// File: rtl/lru4_tracker_chk.sv
module lru4_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       acc_valid,
  input logic [1:0] acc_line,
  input logic [7:0] order_q,
  input logic       pair_q
);
  logic [3:0] seen;
  always_comb begin
    seen = '0;
    for (int i = 0; i < 4; i++) seen[order_q[2*i +: 2]] = 1'b1;
  end

  p_perm_r2: assert property (@(posedge clk) disable iff (!rst_n) seen == 4'hF);
  p_mru_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> order_q[1:0] == $past(acc_line));
  p_victim_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> order_q[7:6] != $past(acc_line));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> $stable(order_q) && $stable(pair_q));
  p_rehit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_line == order_q[1:0] |=> $stable(order_q));
  p_pair_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_line == 2'd0 |=> pair_q);
  p_pair_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_line == 2'd1 |=> !pair_q);
  p_pair_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_line[1] |=> $stable(pair_q));
endmodule

bind lru4_tracker lru4_tracker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_line(acc_line),
  .order_q(order_q), .pair_q(pair_q)
);

// File: tb/tb_lru4_tracker.sv
module tb_lru4_tracker;
  logic clk = 0, rst_n = 0, pair_mode = 0, acc_valid = 0;
  logic [1:0] acc_line = 0;
  logic [1:0] victim;
  int n_cmp = 0, n_bad = 0;
  int q[4];
  bit pb;

  lru4_tracker dut (.clk(clk), .rst_n(rst_n), .pair_mode(pair_mode),
    .acc_valid(acc_valid), .acc_line(acc_line), .victim(victim));

  always #10 clk = ~clk;

  function automatic int exp_victim(bit m);
    return m ? int'(pb) : q[3];
  endfunction

  function automatic void model_ref(int l);
    int p = 0;
    for (int i = 0; i < 4; i++) if (q[i] == l) p = i;
    for (int i = p; i > 0; i--) q[i] = q[i-1];
    q[0] = l;
    if (l == 0) pb = 1;
    if (l == 1) pb = 0;
  endfunction

  task automatic check(string req);
    int e = exp_victim(pair_mode);
    n_cmp++;
    if (int'(victim) != e) begin
      n_bad++;
      $display("FAIL %s: victim=%0d expected=%0d mode=%0b", req, victim, e, pair_mode);
    end
  endtask

  task automatic step(bit v, int l, string req);
    acc_valid = v; acc_line = 2'(l);
    @(posedge clk);
    if (v) model_ref(l);
    @(negedge clk);
    acc_valid = 0;
    check(req);
  endtask

  task automatic set_mode(bit m, string req);
    pair_mode = m; #1; check(req);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    for (int i = 0; i < 4; i++) q[i] = i;
    pb = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    set_mode(0, "R1 four-line reset");
    set_mode(1, "R1 two-line reset");
    set_mode(0, "R1");
    step(1, 3, "R2 ref least recent");
    step(1, 2, "R2 ref new least recent");
    step(1, 2, "R5 repeat most recent");
    step(0, 0, "R4 idle");
    step(0, 3, "R4 idle with line set");
    step(1, 0, "R3 victim after ref");
    step(1, 1, "R2 fill distinct");
    set_mode(1, "R8 mode switch after history");
    step(1, 0, "R6 ref line0");
    step(1, 1, "R6 ref line1");
    step(1, 2, "R7 line2 ignored");
    step(1, 3, "R7 line3 ignored");
    step(0, 0, "R4 idle pair");
    set_mode(0, "R8 four-line tracked in pair mode");
    for (int k = 0; k < 2000; k++) begin
      if ($urandom_range(15) == 0) set_mode(1'($urandom_range(1)), "R8 random mode");
      if ($urandom_range(7) == 0) step(0, int'($urandom_range(3)), "R4 random idle");
      else if ($urandom_range(5) == 0) step(1, q[0], "R5 random rehit");
      else step(1, int'($urandom_range(3)), "R2 R3 R6 R7 random ref");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule